// File: doc/BRIEF.md
# Byte-Lane Static Memory with Idle Power-Down Flag

This block models a word-organized static memory driven by an active-low control interface. A word is selected by the address. Its 16-bit data bus is bidirectional and split into two 8-bit byte lanes. Each lane has its own active-low enable, so a host can move one byte or a whole word in a single access. Reads are combinational from the address and controls, and the bus follows them in the same cycle. Writes are taken on the rising edge of a sampling clock while the write condition holds. This keeps the model synthesizable while still behaving like an asynchronous part to the host.

The output drivers are gated separately for each lane. A lane drives only during a read, and only when its own enable is low. In every other case the lane is released: when the chip is deselected, when outputs are disabled, when the lane enable is high, or when a write is under way. A write wins over output enable. The block also raises a power-down status while deselected. It raises the same status when the address has been held still with no write for a set number of clock edges, and drops it as soon as the address moves or a write begins.

The storage depth is a parameter so that simulation stays small. The address stays 17 bits wide, and only its low bits select a word, so locations repeat every `DEPTH` words.

Top module: `bytelane_sram`

## Requirements
- R1: With `cs_n_i`=0 and `we_n_i`=0 at a rising clock edge and both lane enables low, the word on `dq_io` is stored at the addressed location. The low lane is `dq_io[7:0]` (enable `lb_n_i`) and the high lane is `dq_io[15:8]` (enable `ub_n_i`).
- R2: During a write, a lane whose enable is high keeps its previous contents, while the other lane is updated.
- R3: With `cs_n_i`=0, `oe_n_i`=0 and `we_n_i`=1, each enabled lane drives the stored byte of the addressed word in the same cycle, with no clock edge needed.
- R4: During a read, a lane whose enable is high is released while the other lane drives.
- R5: Both lanes are released when `cs_n_i`=1, when `oe_n_i`=1, or when both lane enables are high.
- R6: When `cs_n_i`=0 and `we_n_i`=0, no lane is driven even if `oe_n_i`=0, and the cycle acts as a write.
- R7: `power_down_o` is 1 whenever `cs_n_i`=1, in the same cycle.
- R8: Suppose a new address is first sampled at some rising edge, then held with no write. `power_down_o` then rises at the `IDLE_CYCLES`-th edge after that one (default 4). It drops in the same cycle when the address differs from the last sampled value or when a write condition is present.
- R9: Synchronous active-high `rst` clears the idle tracking, so `power_down_o` is 0 after reset while `cs_n_i`=0. The storage array is not reset.
- R10: Only the low log2(`DEPTH`) address bits select a word, so address A and address A+`DEPTH` reach the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for writes and idle tracking |
| rst | input | 1 | Synchronous active-high reset of the idle tracking |
| addr_i | input | 17 | Word address |
| dq_io | inout | 16 | Bidirectional data, low lane [7:0], high lane [15:8] |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| lb_n_i | input | 1 | Low lane enable, active low |
| ub_n_i | input | 1 | High lane enable, active low |
| power_down_o | output | 1 | Standby or idle power-down status |

## Verification
Read data, lane release and the clearing of `power_down_o` are combinational. The bench changes inputs at the falling edge and samples 1 ns later, with no clock edge in between. A write lands at the next rising edge, so the bench reads it back only from the following falling edge onward. The idle flag is counted edge by edge. The bench checks that it is still low after `IDLE_CYCLES` edges counted from the edge that captured the new address, and high after one more edge. A pull-up on every bus bit makes a released lane read as all ones over stored zeros, which separates release from driving.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/sram_decode.sv
module sram_decode
  import sram_pkg::*;
(
  input  logic      cs_n,
  input  logic      oe_n,
  input  logic      we_n,
  input  lane_vec_t ben_n,
  output lane_vec_t wr_lane,
  output lane_vec_t rd_lane,
  output logic      wr_any
);
  logic rd_any;
  lane_vec_t ben;

  always_comb begin
    ben    = ~ben_n;
    // write has priority over output enable
    wr_any = ~cs_n & ~we_n;
    rd_any = ~cs_n & ~oe_n & we_n;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_lane[l] = wr_any & ben[l];
    assign rd_lane[l] = rd_any & ben[l];
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= din;
  end

  assign dout = mem[idx];
endmodule

// File: rtl/sram_idle_mon.sv
module sram_idle_mon #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned IDLE_CYCLES = 4,
  localparam int unsigned CNT_W      = $clog2(IDLE_CYCLES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              wr_any,
  output logic              power_down
);
  logic [ADDR_W-1:0] prev_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              idle_q;
  logic              moved;

  assign moved = (addr != prev_q);

  always_ff @(posedge clk) begin
    prev_q <= addr;
    if (rst) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (moved || wr_any) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (!idle_q) begin
      if (cnt_q == CNT_W'(IDLE_CYCLES - 1)) idle_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign power_down = cs_n | (idle_q & ~moved & ~wr_any);
endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import sram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DEPTH       = 1024,
  parameter int unsigned IDLE_CYCLES = 4,
  localparam int unsigned DATA_W     = LANES * LANE_W,
  localparam int unsigned IDX_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  inout  wire  [DATA_W-1:0] dq_io,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              lb_n_i,
  input  logic              ub_n_i,
  output logic              power_down_o
);
  lane_vec_t        wr_lane;
  lane_vec_t        rd_lane;
  logic             wr_any;
  logic [IDX_W-1:0] idx;

  assign idx = addr_i[IDX_W-1:0];

  sram_decode u_dec (
    .cs_n    (cs_n_i),
    .oe_n    (oe_n_i),
    .we_n    (we_n_i),
    .ben_n   ({ub_n_i, lb_n_i}),
    .wr_lane (wr_lane),
    .rd_lane (rd_lane),
    .wr_any  (wr_any)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] rdata;
    sram_lane #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
      .clk   (clk),
      .wr_en (wr_lane[l]),
      .idx   (idx),
      .din   (dq_io[l*LANE_W +: LANE_W]),
      .dout  (rdata)
    );
    assign dq_io[l*LANE_W +: LANE_W] = rd_lane[l] ? rdata : {LANE_W{1'bz}};
  end

  sram_idle_mon #(.ADDR_W(ADDR_W), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr_i),
    .cs_n       (cs_n_i),
    .wr_any     (wr_any),
    .power_down (power_down_o)
  );
endmodule

// File: rtl/sram_checker.sv
module sram_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [1:0]        rd_lane,
  input logic [1:0]        wr_lane,
  input logic              power_down
);
  // R3
  a_r3_read_drive: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !oe_n && we_n) |-> (rd_lane == {~ub_n, ~lb_n}));
  // R4
  a_r4_low_release: assert property (@(posedge clk) disable iff (rst)
    lb_n |-> !rd_lane[0]);
  a_r4_high_release: assert property (@(posedge clk) disable iff (rst)
    ub_n |-> !rd_lane[1]);
  // R5
  a_r5_bus_release: assert property (@(posedge clk) disable iff (rst)
    (cs_n || oe_n) |-> (rd_lane == 2'b00));
  // R6
  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !we_n) |-> (rd_lane == 2'b00 && wr_lane == {~ub_n, ~lb_n}));
  // R7
  a_r7_standby: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> power_down);
  // R8
  a_r8_clear_on_move: assert property (@(posedge clk) disable iff (rst)
    (!$stable(addr) && !cs_n) |-> !power_down);
  // R9
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !cs_n) |-> !power_down);
endmodule

bind bytelane_sram sram_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr       (addr_i),
  .cs_n       (cs_n_i),
  .oe_n       (oe_n_i),
  .we_n       (we_n_i),
  .lb_n       (lb_n_i),
  .ub_n       (ub_n_i),
  .rd_lane    (rd_lane),
  .wr_lane    (wr_lane),
  .power_down (power_down_o)
);

// File: tb/bytelane_sram_bench.sv
`timescale 1ns/1ps
module bytelane_sram_bench;
  localparam int unsigned ADDR_W = 17;
  localparam int unsigned DEPTH  = 1024;
  localparam int unsigned IDLE   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic drv = 1'b0;
  logic [15:0] wdata = '0;
  wire  [15:0] dq;
  logic pd;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign dq = drv ? wdata : 16'hzzzz;
  for (genvar i = 0; i < 16; i++) begin : g_pull
    pullup (dq[i]);
  end

  bytelane_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDLE_CYCLES(IDLE)) u_bytelane_sram (
    .clk(clk), .rst(rst), .addr_i(addr), .dq_io(dq), .cs_n_i(cs_n),
    .oe_n_i(oe_n), .we_n_i(we_n), .lb_n_i(lb_n), .ub_n_i(ub_n),
    .power_down_o(pd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1; drv = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                    input logic lbn, input logic ubn, input logic oen);
    @(negedge clk);
    addr = a; wdata = d; drv = 1'b1;
    cs_n = 1'b0; we_n = 1'b0; oe_n = oen; lb_n = lbn; ub_n = ubn;
    @(posedge clk);
    @(negedge clk);
    idle_bus();
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic lbn, input logic ubn,
                    output logic [15:0] v);
    @(negedge clk);
    addr = a; drv = 1'b0;
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; lb_n = lbn; ub_n = ubn;
    #1 v = dq;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle_bus();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cs_n = 1'b0;
    #1 chk("R9 power_down after reset", {15'd0, pd}, 16'd0);
    cs_n = 1'b1;
  endtask

  task automatic t_word();
    logic [15:0] v;
    wr(17'd5, 16'h1234, 1'b0, 1'b0, 1'b1);
    wr(17'd6, 16'hABCD, 1'b0, 1'b0, 1'b1);
    rd(17'd5, 1'b0, 1'b0, v); chk("R1/R3 word read addr5", v, 16'h1234);
    rd(17'd6, 1'b0, 1'b0, v); chk("R1/R3 word read addr6", v, 16'hABCD);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    wr(17'd5, 16'hFF77, 1'b0, 1'b1, 1'b1);
    rd(17'd5, 1'b0, 1'b0, v); chk("R2 low-only write", v, 16'h1277);
    wr(17'd5, 16'h9900, 1'b1, 1'b0, 1'b1);
    rd(17'd5, 1'b0, 1'b0, v); chk("R2 high-only write", v, 16'h9977);
  endtask

  task automatic t_lanes();
    logic [15:0] v;
    wr(17'd9, 16'h0000, 1'b0, 1'b0, 1'b1);
    rd(17'd9, 1'b0, 1'b1, v); chk("R4 high lane released", v, 16'hFF00);
    rd(17'd9, 1'b1, 1'b0, v); chk("R4 low lane released", v, 16'h00FF);
    rd(17'd9, 1'b0, 1'b0, v); chk("R3 zeros driven", v, 16'h0000);
  endtask

  task automatic t_release();
    @(negedge clk);
    addr = 17'd9; drv = 1'b0; we_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
    cs_n = 1'b1; oe_n = 1'b0;
    #1 chk("R5 released on deselect", dq, 16'hFFFF);
    chk("R7 standby flag", {15'd0, pd}, 16'd1);
    cs_n = 1'b0; oe_n = 1'b1;
    #1 chk("R5 released on output disable", dq, 16'hFFFF);
    oe_n = 1'b0; lb_n = 1'b1; ub_n = 1'b1;
    #1 chk("R5 released with both lanes off", dq, 16'hFFFF);
    idle_bus();
  endtask

  task automatic t_priority();
    logic [15:0] v;
    @(negedge clk);
    addr = 17'd9; drv = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1 chk("R6 no drive during write", dq, 16'hFFFF);
    idle_bus();
    wr(17'd10, 16'h5A5A, 1'b0, 1'b0, 1'b0);
    rd(17'd10, 1'b0, 1'b0, v); chk("R6 write with oe low stored", v, 16'h5A5A);
  endtask

  task automatic t_alias();
    logic [15:0] v;
    wr(17'(3 + DEPTH), 16'hC0DE, 1'b0, 1'b0, 1'b1);
    rd(17'd3, 1'b0, 1'b0, v); chk("R10 alias addr3", v, 16'hC0DE);
  endtask

  task automatic t_idle();
    @(negedge clk);
    idle_bus();
    cs_n = 1'b0; addr = 17'd40;
    repeat (IDLE) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet idle", {15'd0, pd}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 idle reached", {15'd0, pd}, 16'd1);
    addr = 17'd41;
    #1 chk("R8 clear on address move", {15'd0, pd}, 16'd0);
    repeat (IDLE + 1) @(posedge clk);
    @(negedge clk);
    chk("R8 idle again", {15'd0, pd}, 16'd1);
    wdata = 16'h0101; drv = 1'b1; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    #1 chk("R8 clear on write", {15'd0, pd}, 16'd0);
    @(negedge clk);
    idle_bus();
    #1 chk("R7 deselect raises flag", {15'd0, pd}, 16'd1);
  endtask

  initial begin
    t_reset();
    t_word();
    t_mask();
    t_lanes();
    t_release();
    t_priority();
    t_alias();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule